// File: doc/BRIEF.md
# USB Frame-Number and Isochronous-Error Status Register

This block is one 32-bit control/status word inside a full-speed USB device controller. The packet receiver sends it strobes. A start-of-frame strobe comes with the 11-bit frame number of that packet. A corruption strobe for each isochronous endpoint comes with a code that says which part of the packet was damaged. From the frame strobe the register keeps the three most significant frame-number bits. It also raises a start-of-frame interrupt request, which software can mask. From the corruption strobes it keeps one sticky error flag per isochronous endpoint. Only a damaged data payload sets a flag.

Software reads the word at a single address. It clears the request and the error flags by writing ones to them. The mask bit is read/write. Writing 1 to the mask stops new requests from being raised and leaves a pending request in place. The interrupt line comes straight from the request register, and every error flag has its own status output for the endpoint interrupt logic. A read returns the word in the same cycle as the address. A write takes effect at the next clock edge.

Top module: `usb_sof_status_reg`

## Requirements
- R1: After reset the word reads 0x0000_0040: frame bits 0, error flags 0, mask (bit 6) 1, request (bit 7) 0.
- R2: On a start-of-frame strobe, bits 2:0 take frame-number bits 10:8 and show them from the next cycle on.
- R3: A corruption strobe for endpoint i with code 0 (payload damaged) sets error flag bit 3+i on the next edge, and the flag stays set.
- R4: A corruption strobe with code 1 (token damaged), code 2 (sync or PID damaged) or code 3 (unclassified) leaves the error flags unchanged.
- R5: Writing 1 to an error flag bit clears it. Writing 0 leaves it unchanged.
- R6: Bit 6 is the mask. Every write to the address loads it from write-data bit 6.
- R7: Bit 7 (request) sets on a start-of-frame strobe when the mask, as it stood before the edge, is 0. When the mask is 1 the request does not set.
- R8: Writing the mask to 1 does not clear a pending request.
- R9: Writing 1 to bit 7 clears the request. Writing 0 to bit 7 leaves it unchanged.
- R10: If a set event and a write-1 clear reach the same flag or request in the same cycle, the bit ends up set.
- R11: Output `irq` always equals bit 7, and `ep_err_stat[i]` always equals bit 3+i.
- R12: Bits 31:8 read 0. A read at any other address returns 0, and a write to any other address changes nothing.
- R13: Bits 2:0 are read-only. A bus write does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_stb | input | 1 | Start-of-frame received (one-cycle pulse) |
| sof_frame | input | 11 | Frame number carried by that packet |
| ep_corrupt_stb | input | 3 | Per-endpoint corrupted-packet pulse |
| corrupt_kind | input | 2 | Damage code: 0 payload, 1 token, 2 sync/PID, 3 unclassified |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the address |
| irq | output | 1 | Start-of-frame interrupt request |
| ep_err_stat | output | 3 | Per-endpoint sticky error status |

## Verification
Two pairs of functions can land in the same cycle. A payload-corruption strobe can meet a write-1 clear of the same flag, and a start-of-frame strobe with the mask at 0 can meet a write-1 clear of the request. The bench provokes both on purpose, once directed and many times through random stimulus that drives strobes and writes on the same edges. A reference model applies the set-wins rule to judge the next read. Mask writes that arrive together with a start-of-frame strobe are judged against the mask value as it stood before the edge.

// File: rtl/usbfn_pkg.sv
package usbfn_pkg;

  typedef enum logic [1:0] {
    CK_PAYLOAD  = 2'd0,
    CK_TOKEN    = 2'd1,
    CK_SYNC_PID = 2'd2,
    CK_OTHER    = 2'd3
  } corrupt_kind_e;

  localparam int unsigned WORD_W = 32;

endpackage

// File: rtl/usbfn_frame_cap.sv
module usbfn_frame_cap #(
  parameter int unsigned FRAME_W = 11,
  parameter int unsigned HI_W    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sof_stb,
  input  logic [FRAME_W-1:0] sof_frame,
  output logic [HI_W-1:0]    hi_q
);
  localparam int unsigned LO_W = FRAME_W - HI_W;

  always_ff @(posedge clk) begin
    if (rst)          hi_q <= '0;
    else if (sof_stb) hi_q <= sof_frame[FRAME_W-1:LO_W];
  end

  // R2
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    sof_stb |=> hi_q == $past(sof_frame[FRAME_W-1:LO_W]));
  // R13
  a_r13_hold: assert property (@(posedge clk) disable iff (rst)
    !sof_stb |=> $stable(hi_q));
endmodule

// File: rtl/usbfn_err_flag.sv
module usbfn_err_flag
  import usbfn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit_stb,
  input  logic [1:0] kind,
  input  logic       clr,
  output logic       flag_q
);
  logic payload_bad;
  assign payload_bad = hit_stb && (kind == CK_PAYLOAD);

  always_ff @(posedge clk) begin
    if (rst)              flag_q <= 1'b0;
    else if (payload_bad) flag_q <= 1'b1;
    else if (clr)         flag_q <= 1'b0;
  end

  // R3 / R10
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (hit_stb && kind == 2'd0) |=> flag_q);
  // R4
  a_r4_no_false_set: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && (!hit_stb || kind != 2'd0)) |=> !flag_q);
  // R5
  a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
    (clr && !(hit_stb && kind == 2'd0)) |=> !flag_q);
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/usbfn_sof_irq.sv
module usbfn_sof_irq (
  input  logic clk,
  input  logic rst,
  input  logic sof_stb,
  input  logic wr_hit,
  input  logic wr_mask,
  input  logic wr_req_clr,
  output logic mask_q,
  output logic req_q
);
  logic req_set;
  assign req_set = sof_stb && !mask_q;

  always_ff @(posedge clk) begin
    if (rst)         mask_q <= 1'b1;
    else if (wr_hit) mask_q <= wr_mask;
  end

  always_ff @(posedge clk) begin
    if (rst)                      req_q <= 1'b0;
    else if (req_set)             req_q <= 1'b1;
    else if (wr_hit && wr_req_clr) req_q <= 1'b0;
  end

  // R7
  a_r7_masked: assert property (@(posedge clk) disable iff (rst)
    (!req_q && mask_q) |=> !req_q);
  // R10
  a_r10_req_set_wins: assert property (@(posedge clk) disable iff (rst)
    (sof_stb && !mask_q) |=> req_q);
  // R8
  a_r8_mask_keeps_req: assert property (@(posedge clk) disable iff (rst)
    (req_q && !(wr_hit && wr_req_clr)) |=> req_q);
  // R6
  a_r6_mask_load: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> mask_q == $past(wr_mask));
endmodule

// File: rtl/usb_sof_status_reg.sv
module usb_sof_status_reg
  import usbfn_pkg::*;
#(
  parameter int unsigned FRAME_W  = 11,
  parameter int unsigned FN_HI_W  = 3,
  parameter int unsigned NUM_EP   = 3,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sof_stb,
  input  logic [FRAME_W-1:0] sof_frame,
  input  logic [NUM_EP-1:0]  ep_corrupt_stb,
  input  logic [1:0]         corrupt_kind,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               irq,
  output logic [NUM_EP-1:0]  ep_err_stat
);
  localparam int unsigned ERR_LSB  = FN_HI_W;
  localparam int unsigned MASK_BIT = ERR_LSB + NUM_EP;
  localparam int unsigned REQ_BIT  = MASK_BIT + 1;
  localparam int unsigned USED_W   = REQ_BIT + 1;

  logic                addr_hit, wr_hit;
  logic [FN_HI_W-1:0]  fn_hi;
  logic [NUM_EP-1:0]   err_q;
  logic                mask_q, req_q;
  logic [WORD_W-1:0]   word;

  assign addr_hit = bus_sel && (bus_addr == REG_ADDR);
  assign wr_hit   = addr_hit && bus_we;

  usbfn_frame_cap #(.FRAME_W(FRAME_W), .HI_W(FN_HI_W)) u_frame (
    .clk(clk), .rst(rst), .sof_stb(sof_stb), .sof_frame(sof_frame), .hi_q(fn_hi)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    usbfn_err_flag u_flag (
      .clk(clk), .rst(rst),
      .hit_stb(ep_corrupt_stb[i]),
      .kind(corrupt_kind),
      .clr(wr_hit && bus_wdata[ERR_LSB+i]),
      .flag_q(err_q[i])
    );
  end

  usbfn_sof_irq u_irq (
    .clk(clk), .rst(rst), .sof_stb(sof_stb),
    .wr_hit(wr_hit), .wr_mask(bus_wdata[MASK_BIT]),
    .wr_req_clr(bus_wdata[REQ_BIT]),
    .mask_q(mask_q), .req_q(req_q)
  );

  always_comb begin
    word = '0;
    word[FN_HI_W-1:0]            = fn_hi;
    word[MASK_BIT-1:ERR_LSB]     = err_q;
    word[MASK_BIT]               = mask_q;
    word[REQ_BIT]                = req_q;
  end

  assign bus_rdata   = addr_hit ? word : '0;
  assign irq         = req_q;
  assign ep_err_stat = err_q;

  // R12
  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[WORD_W-1:USED_W] == '0);
  a_r12_other_addr: assert property (@(posedge clk) disable iff (rst)
    !addr_hit |-> bus_rdata == '0);
  // R11
  a_r11_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    addr_hit |-> bus_rdata[REQ_BIT] == irq);
endmodule

// File: tb/usb_sof_status_reg_bench.sv
module usb_sof_status_reg_bench;
  localparam logic [7:0] RA = 8'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sof_stb = 1'b0;
  logic [10:0] sof_frame = '0;
  logic [2:0]  ep_corrupt_stb = '0;
  logic [1:0]  corrupt_kind = '0;
  logic        bus_sel = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = RA;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [2:0]  ep_err_stat;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [2:0] m_fhi;
  logic [2:0] m_err;
  logic       m_mask;
  logic       m_req;

  always #2.5 clk = ~clk;

  usb_sof_status_reg u_usb_sof_status_reg (
    .clk(clk), .rst(rst), .sof_stb(sof_stb), .sof_frame(sof_frame),
    .ep_corrupt_stb(ep_corrupt_stb), .corrupt_kind(corrupt_kind),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .ep_err_stat(ep_err_stat)
  );

  function automatic logic [31:0] pack_model(logic [2:0] f, logic [2:0] e,
                                             logic mk, logic rq);
    return {24'd0, rq, mk, e, f};
  endfunction

  function automatic logic [2:0] next_err(logic [2:0] e, logic [2:0] stb,
                                          logic [1:0] k, logic wr, logic [2:0] clrb);
    logic [2:0] n = e;
    for (int i = 0; i < 3; i++) begin
      if (stb[i] && k == 2'd0) n[i] = 1'b1;
      else if (wr && clrb[i])  n[i] = 1'b0;
    end
    return n;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic s, logic [10:0] fr, logic [2:0] cs,
                      logic [1:0] k, logic w, logic [7:0] a, logic [31:0] wd);
    logic hit = w && (a == RA);
    sof_stb = s; sof_frame = fr; ep_corrupt_stb = cs; corrupt_kind = k;
    bus_we = w; bus_addr = a; bus_wdata = wd;
    m_err = next_err(m_err, cs, k, hit, wd[5:3]);
    if (s && !m_mask)        m_req = 1'b1;
    else if (hit && wd[7])   m_req = 1'b0;
    if (s) m_fhi = fr[10:8];
    if (hit) m_mask = wd[6];
    @(posedge clk); #1;
    sof_stb = 0; ep_corrupt_stb = '0; bus_we = 0; bus_addr = RA; bus_wdata = '0;
    #1;
    check(req, bus_rdata, pack_model(m_fhi, m_err, m_mask, m_req));
    check("R11 irq", {31'd0, irq}, {31'd0, m_req});
    check("R11 stat", {29'd0, ep_err_stat}, {29'd0, m_err});
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_fhi = '0; m_err = '0; m_mask = 1'b1; m_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check("R1 reset", bus_rdata, 32'h0000_0040);
    // R2, R7 masked
    step("R2 R7 masked sof", 1, 11'h5A3, 0, 0, 0, RA, 0);
    step("R6 unmask", 0, 0, 0, 0, 1, RA, 32'h0);
    step("R7 request set", 1, 11'h2FF, 0, 0, 0, RA, 0);
    step("R8 mask keeps req", 0, 0, 0, 0, 1, RA, 32'h40);
    step("R7 masked no new", 1, 11'h7FF, 0, 0, 0, RA, 0);
    step("R9 write0 keeps req", 0, 0, 0, 0, 1, RA, 32'h40);
    step("R9 w1c req", 0, 0, 0, 0, 1, RA, 32'hC0);
    step("R3 payload ep1", 0, 0, 3'b010, 2'd0, 0, RA, 0);
    step("R4 token ep0", 0, 0, 3'b001, 2'd1, 0, RA, 0);
    step("R4 syncpid ep2", 0, 0, 3'b100, 2'd2, 0, RA, 0);
    step("R4 other ep0", 0, 0, 3'b001, 2'd3, 0, RA, 0);
    step("R3 payload ep2", 0, 0, 3'b100, 2'd0, 0, RA, 0);
    step("R5 write0 keeps", 0, 0, 0, 0, 1, RA, 32'h40);
    step("R5 w1c ep1", 0, 0, 0, 0, 1, RA, 32'h50);
    step("R10 set beats clear", 0, 0, 3'b100, 2'd0, 1, RA, 32'h60);
    step("R6 unmask again", 0, 0, 0, 0, 1, RA, 32'h0);
    step("R10 req set beats clear", 1, 11'h123, 0, 0, 1, RA, 32'h80);
    step("R13 frame read-only", 0, 0, 0, 0, 1, RA, 32'hFFFF_FF87);
    step("R12 other addr write", 0, 0, 0, 0, 1, 8'h1C, 32'hFFFF_FFFF);
    bus_addr = 8'h1C; #1;
    check("R12 other addr read", bus_rdata, 32'h0);
    bus_addr = RA; @(negedge clk);
    for (int t = 0; t < 400; t++) begin
      logic [31:0] r = $urandom;
      logic [31:0] wd = $urandom;
      step("R12 random", r[0] & r[1], r[12:2], r[15:13] & {3{r[16]}}, r[18:17],
           r[19] & r[20], r[21] ? 8'h20 : RA, wd);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule